// File: doc/BRIEF.md
# Power-State Handshake Sequencer

This controller sits on the management side of a two-processor chip and orders the power handshake between a supervisor and an application processor. Once system reset is lifted, it first turns on the core clock and then releases core reset. It next asks in turn for the clock generator and DLL to be programmed, for the pads and GPIO routing to be set up, and for the user clock to reach full speed. Each step is a level request held until a matching done flag returns. Only after that does it let the user logic out of reset. It then waits for the application processor to report that it is running. When the report arrives it switches off external clock-generator power through a level output and enters normal operation.

In normal operation, power requests arrive through a mailbox interrupt that carries a one-bit command. A go-low request reprograms the clocking to its lowest-power setting. A go-full request, issued after an RTC wake, reprograms it back to full power and answers with an acknowledge pulse. Every configuration wait is guarded by a programmable timeout. If a timeout expires, the sequencer parks in a fault state that only reset can leave.

Top module: `pwrhs_seq`

## Requirements
- R1: After reset is lifted, `core_clk_en` rises while `core_rst_n` is still low, and `core_rst_n` rises exactly one cycle later. During reset every output is low.
- R2: `clk_cfg_req` (with `clk_cfg_low`=0), then `pad_cfg_req`, then `uclk_full_req` are asserted one at a time. Each is held until its own done flag is sampled high. The next request is not raised before that done flag is seen.
- R3: `user_rst_n` stays low until `uclk_full_done` has been sampled during the user-clock request. It rises in the following cycle and then stays high.
- R4: `run_ok` sampled while waiting for the running report sets `ext_cpg_off` high in the next cycle, and `ext_cpg_off` stays high until reset.
- R5: A mailbox request accepted before `ext_cpg_off` is high is consumed and dropped. No configuration request follows and `low_pwr` stays low.
- R6: A go-low request (`mbox_go_low`=1) in normal operation raises `clk_cfg_req` with `clk_cfg_low`=1 on the cycle after the acceptance pulse. After `clk_cfg_done`, `low_pwr` is high.
- R7: A go-full request (`mbox_go_low`=0) while in low power raises `clk_cfg_req` with `clk_cfg_low`=0. After `clk_cfg_done`, `full_ack` is high for exactly one cycle and `low_pwr` is low.
- R8: A go-full request in normal operation produces the one-cycle `full_ack` on the cycle after the acceptance pulse, with no `clk_cfg_req`.
- R9: Each accepted request is answered by a one-cycle `mbox_irq_clr` pulse. A request accepted during a reconfiguration is held and served once the reconfiguration finishes.
- R10: If a configuration request stays unanswered while its wait counter, which starts at 0 in the first cycle of the wait, equals `tmo_limit`, `fault` rises in the next cycle. It stays high, with all configuration requests low, until reset.
- R11: A go-low request that arrives while already in low power is consumed with no effect: `low_pwr` stays high and no configuration request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | TMO_W | Timeout limit for every configuration wait, in cycles |
| clk_cfg_done | input | 1 | Clock generator and DLL programming finished |
| pad_cfg_done | input | 1 | Pad and GPIO routing finished |
| uclk_full_done | input | 1 | User clock running at full speed |
| run_ok | input | 1 | Application processor reports that it is running |
| mbox_irq | input | 1 | Mailbox interrupt, level |
| mbox_go_low | input | 1 | Mailbox command: 1 go low power, 0 go full power |
| core_clk_en | output | 1 | Core clock enable toward the harness |
| core_rst_n | output | 1 | Core reset, active low |
| clk_cfg_req | output | 1 | Request to program clock generator and DLL |
| clk_cfg_low | output | 1 | With `clk_cfg_req`: 1 lowest-power setting, 0 full power |
| pad_cfg_req | output | 1 | Request to configure pad routing and GPIO |
| uclk_full_req | output | 1 | Request to raise the user clock to full speed |
| user_rst_n | output | 1 | User-logic reset, active low |
| ext_cpg_off | output | 1 | External clock-generator power off, level |
| mbox_irq_clr | output | 1 | One-cycle mailbox interrupt clear |
| full_ack | output | 1 | One-cycle went-full-power acknowledge |
| low_pwr | output | 1 | Resting in low-power state |
| fault | output | 1 | Sticky timeout fault |

## Verification
Two events can coincide. A new mailbox request can be accepted in the same stretch of cycles in which a clock reconfiguration is still pending, and a go-full request can become pending at the very edge on which the go-low reconfiguration completes. The bench provokes both by raising the interrupt while `clk_cfg_req` is still held, and only then returning `clk_cfg_done`. It judges the result by requiring `low_pwr` in the following cycle, then a fresh `clk_cfg_req` with `clk_cfg_low`=0, and finally one `full_ack` pulse. Random loops mix go-low, go-full and ignored requests with random done delays below the timeout.

// File: rtl/pwrhs_pkg.sv
package pwrhs_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_CLK_CFG  = 4'd1,
    ST_PAD_CFG  = 4'd2,
    ST_UCLK_UP  = 4'd3,
    ST_URST_REL = 4'd4,
    ST_WAIT_OK  = 4'd5,
    ST_RUN      = 4'd6,
    ST_LOW_CFG  = 4'd7,
    ST_LOW      = 4'd8,
    ST_FULL_CFG = 4'd9,
    ST_ACK      = 4'd10,
    ST_ERROR    = 4'd11
  } pstate_t;

  function automatic logic is_cfg_wait(pstate_t s);
    return (s == ST_CLK_CFG) || (s == ST_PAD_CFG) || (s == ST_UCLK_UP) ||
           (s == ST_LOW_CFG) || (s == ST_FULL_CFG);
  endfunction

endpackage

// File: rtl/pwrhs_rst_sync.sv
module pwrhs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwrhs_tmo.sv
module pwrhs_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             waiting,
  input  logic             done,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart || !waiting) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != limit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = waiting && !done && (cnt_q == limit);
endmodule

// File: rtl/pwrhs_mbox.sv
module pwrhs_mbox (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic go_low,
  input  logic ok_seen,
  input  logic take,
  output logic pend_v,
  output logic pend_low,
  output logic irq_clr
);
  logic pend_v_q, pend_v_d, pend_low_q, pend_low_d, clr_q, accept;

  assign accept = irq && !clr_q && !pend_v_q;

  always_comb begin
    pend_v_d   = pend_v_q;
    pend_low_d = pend_low_q;
    if (take) pend_v_d = 1'b0;
    if (accept && ok_seen) begin
      pend_v_d   = 1'b1;
      pend_low_d = go_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_low_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      pend_v_q   <= pend_v_d;
      pend_low_q <= pend_low_d;
      clr_q      <= accept;
    end
  end

  assign pend_v   = pend_v_q;
  assign pend_low = pend_low_q;
  assign irq_clr  = clr_q;
endmodule

// File: rtl/pwrhs_fsm.sv
module pwrhs_fsm
  import pwrhs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clk_cfg_done,
  input  logic    pad_cfg_done,
  input  logic    uclk_full_done,
  input  logic    run_ok,
  input  logic    pend_v,
  input  logic    pend_low,
  input  logic    expire,
  output pstate_t state,
  output logic    waiting,
  output logic    wait_done,
  output logic    restart,
  output logic    take,
  output logic    clk_on,
  output logic    cpg_off
);
  pstate_t state_q, state_d;
  logic    clk_on_q, cpg_off_q, cpg_off_d;

  always_comb begin
    unique case (state_q)
      ST_CLK_CFG, ST_LOW_CFG, ST_FULL_CFG: wait_done = clk_cfg_done;
      ST_PAD_CFG:                          wait_done = pad_cfg_done;
      ST_UCLK_UP:                          wait_done = uclk_full_done;
      default:                             wait_done = 1'b0;
    endcase
  end

  assign waiting = is_cfg_wait(state_q);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    unique case (state_q)
      ST_RESET:    if (clk_on_q) state_d = ST_CLK_CFG;
      ST_CLK_CFG:  if (wait_done) state_d = ST_PAD_CFG;
      ST_PAD_CFG:  if (wait_done) state_d = ST_UCLK_UP;
      ST_UCLK_UP:  if (wait_done) state_d = ST_URST_REL;
      ST_URST_REL: state_d = ST_WAIT_OK;
      ST_WAIT_OK:  if (run_ok) state_d = ST_RUN;
      ST_RUN: if (pend_v) begin
        take    = 1'b1;
        state_d = pend_low ? ST_LOW_CFG : ST_ACK;
      end
      ST_LOW_CFG:  if (wait_done) state_d = ST_LOW;
      ST_LOW: if (pend_v) begin
        take    = 1'b1;
        state_d = pend_low ? ST_LOW : ST_FULL_CFG;
      end
      ST_FULL_CFG: if (wait_done) state_d = ST_ACK;
      ST_ACK:      state_d = ST_RUN;
      default:     state_d = ST_ERROR;
    endcase
    if (waiting && expire) state_d = ST_ERROR;
  end

  assign restart   = (state_d != state_q);
  assign cpg_off_d = cpg_off_q || ((state_q == ST_WAIT_OK) && run_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET;
      clk_on_q  <= 1'b0;
      cpg_off_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      clk_on_q  <= 1'b1;
      cpg_off_q <= cpg_off_d;
    end
  end

  assign state   = state_q;
  assign clk_on  = clk_on_q;
  assign cpg_off = cpg_off_q;
endmodule

// File: rtl/pwrhs_seq.sv
module pwrhs_seq
  import pwrhs_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             clk_cfg_done,
  input  logic             pad_cfg_done,
  input  logic             uclk_full_done,
  input  logic             run_ok,
  input  logic             mbox_irq,
  input  logic             mbox_go_low,
  output logic             core_clk_en,
  output logic             core_rst_n,
  output logic             clk_cfg_req,
  output logic             clk_cfg_low,
  output logic             pad_cfg_req,
  output logic             uclk_full_req,
  output logic             user_rst_n,
  output logic             ext_cpg_off,
  output logic             mbox_irq_clr,
  output logic             full_ack,
  output logic             low_pwr,
  output logic             fault
);
  logic    rst_int_n, waiting, wait_done, restart, take;
  logic    pend_v, pend_low, expire, clk_on, cpg_off, urst_q;
  pstate_t state;

  pwrhs_rst_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  pwrhs_mbox u_mbox (
    .clk(clk), .rst_n(rst_int_n), .irq(mbox_irq), .go_low(mbox_go_low),
    .ok_seen(cpg_off), .take(take), .pend_v(pend_v), .pend_low(pend_low),
    .irq_clr(mbox_irq_clr)
  );

  pwrhs_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .waiting(waiting),
    .done(wait_done), .limit(tmo_limit), .expire(expire)
  );

  pwrhs_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .clk_cfg_done(clk_cfg_done),
    .pad_cfg_done(pad_cfg_done), .uclk_full_done(uclk_full_done),
    .run_ok(run_ok), .pend_v(pend_v), .pend_low(pend_low), .expire(expire),
    .state(state), .waiting(waiting), .wait_done(wait_done),
    .restart(restart), .take(take), .clk_on(clk_on), .cpg_off(cpg_off)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                  urst_q <= 1'b0;
    else if (state == ST_URST_REL)   urst_q <= 1'b1;
  end

  assign core_clk_en   = clk_on;
  assign core_rst_n    = clk_on && (state != ST_RESET);
  assign clk_cfg_req   = (state == ST_CLK_CFG) || (state == ST_LOW_CFG) ||
                         (state == ST_FULL_CFG);
  assign clk_cfg_low   = (state == ST_LOW_CFG);
  assign pad_cfg_req   = (state == ST_PAD_CFG);
  assign uclk_full_req = (state == ST_UCLK_UP);
  assign user_rst_n    = urst_q || (state == ST_URST_REL);
  assign ext_cpg_off   = cpg_off;
  assign full_ack      = (state == ST_ACK);
  assign low_pwr       = (state == ST_LOW);
  assign fault         = (state == ST_ERROR);
endmodule

// File: rtl/pwrhs_seq_chk.sv
module pwrhs_seq_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             clk_cfg_done,
  input logic             pad_cfg_done,
  input logic             uclk_full_done,
  input logic             run_ok,
  input logic             mbox_irq,
  input logic             mbox_go_low,
  input logic             core_clk_en,
  input logic             core_rst_n,
  input logic             clk_cfg_req,
  input logic             clk_cfg_low,
  input logic             pad_cfg_req,
  input logic             uclk_full_req,
  input logic             user_rst_n,
  input logic             ext_cpg_off,
  input logic             mbox_irq_clr,
  input logic             full_ack,
  input logic             low_pwr,
  input logic             fault
);
  assert_clk_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |-> core_clk_en);

  assert_pad_after_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_cfg_req) |-> ($past(clk_cfg_req) && $past(clk_cfg_done)));

  assert_one_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_cfg_req, pad_cfg_req, uclk_full_req}));

  assert_user_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_rst_n) |-> ($past(uclk_full_req) && $past(uclk_full_done)));

  assert_cpg_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cpg_off |=> ext_cpg_off);

  assert_cpg_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_cpg_off) |-> $past(run_ok));

  assert_no_early_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cpg_off |-> (!clk_cfg_low && !low_pwr));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_ack |=> !full_ack);

  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_irq_clr |=> !mbox_irq_clr);

  assert_clr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_irq_clr |-> $past(mbox_irq));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!clk_cfg_req && !pad_cfg_req && !uclk_full_req && !full_ack));
endmodule

bind pwrhs_seq pwrhs_seq_chk #(.TMO_W(TMO_W)) u_chk (.*);

// File: tb/pwrhs_seq_test.sv
module pwrhs_seq_test;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [TW-1:0] tmo_limit;
  logic clk_cfg_done, pad_cfg_done, uclk_full_done, run_ok, mbox_irq, mbox_go_low;
  logic core_clk_en, core_rst_n, clk_cfg_req, clk_cfg_low, pad_cfg_req;
  logic uclk_full_req, user_rst_n, ext_cpg_off, mbox_irq_clr, full_ack, low_pwr, fault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwrhs_seq #(.TMO_W(TW)) uut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int max);
    return int'($urandom % (max + 1));
  endfunction

  task automatic do_reset(int limit);
    rst_n = 1'b0; tmo_limit = TW'(limit);
    clk_cfg_done = 0; pad_cfg_done = 0; uclk_full_done = 0;
    run_ok = 0; mbox_irq = 0; mbox_go_low = 0;
    repeat (3) tick();
    chk("R1 reset clk_en", core_clk_en, 0);
    chk("R1 reset core_rst", core_rst_n, 0);
    chk("R1 reset user_rst", user_rst_n, 0);
    chk("R1 reset outputs", {ext_cpg_off, fault, clk_cfg_req, full_ack, low_pwr}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_clk_en();
    for (int n = 0; n < 10 && !core_clk_en; n++) tick();
    chk("R1 clk_en rises", core_clk_en, 1);
    chk("R1 core_rst still low", core_rst_n, 0);
    tick();
    chk("R1 core_rst one cycle later", core_rst_n, 1);
  endtask

  task automatic send_req(bit low);
    int n;
    mbox_go_low = low; mbox_irq = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!mbox_irq_clr && n < 20);
    chk("R9 irq clear pulse", mbox_irq_clr, 1);
    mbox_irq = 1'b0;
  endtask

  task automatic bring_up(int d1, int d2, int d3, bit early);
    wait_clk_en();
    chk("R2 clk cfg first", clk_cfg_req, 1);
    chk("R2 clk cfg full setting", clk_cfg_low, 0);
    repeat (d1) begin chk("R2 pad waits", pad_cfg_req, 0); chk("R2 clk held", clk_cfg_req, 1); tick(); end
    clk_cfg_done = 1; tick(); clk_cfg_done = 0;
    chk("R2 pad after clk", pad_cfg_req, 1);
    chk("R2 clk dropped", clk_cfg_req, 0);
    repeat (d2) begin chk("R2 uclk waits", uclk_full_req, 0); chk("R3 user rst low", user_rst_n, 0); tick(); end
    pad_cfg_done = 1; tick(); pad_cfg_done = 0;
    chk("R2 uclk after pad", uclk_full_req, 1);
    repeat (d3) begin chk("R3 user rst held", user_rst_n, 0); tick(); end
    uclk_full_done = 1; tick(); uclk_full_done = 0;
    chk("R3 user rst released", user_rst_n, 1);
    tick();
    if (early) begin
      send_req(1'b1);
      tick();
      chk("R9 clear is one cycle", mbox_irq_clr, 0);
      repeat (3) begin chk("R5 early ignored cfg", clk_cfg_req, 0); chk("R5 early low", low_pwr, 0); tick(); end
      chk("R4 cpg still on", ext_cpg_off, 0);
    end
    run_ok = 1; tick(); run_ok = 0;
    chk("R4 cpg off", ext_cpg_off, 1);
    repeat (2) begin tick(); chk("R5 nothing pending", clk_cfg_req, 0); end
    chk("R3 user rst stays", user_rst_n, 1);
  endtask

  task automatic full_in_run();
    send_req(1'b0);
    tick();
    chk("R8 ack in run", full_ack, 1);
    chk("R8 no reconfig", clk_cfg_req, 0);
    chk("R9 clear one cycle", mbox_irq_clr, 0);
    tick();
    chk("R8 ack one cycle", full_ack, 0);
  endtask

  task automatic go_low(int d, bit wake_during);
    send_req(1'b1);
    tick();
    chk("R6 low cfg req", clk_cfg_req, 1);
    chk("R6 low setting", clk_cfg_low, 1);
    if (wake_during) begin
      send_req(1'b0);
      chk("R9 latched during cfg", clk_cfg_req, 1);
    end
    repeat (d) tick();
    chk("R6 low cfg held", clk_cfg_req, 1);
    clk_cfg_done = 1; tick(); clk_cfg_done = 0;
    chk("R6 low state", low_pwr, 1);
    chk("R6 low cfg dropped", clk_cfg_req, 0);
  endtask

  task automatic finish_full(int d);
    chk("R7 full cfg req", clk_cfg_req, 1);
    chk("R7 full setting", clk_cfg_low, 0);
    repeat (d) tick();
    clk_cfg_done = 1; tick(); clk_cfg_done = 0;
    chk("R7 went full ack", full_ack, 1);
    chk("R7 left low", low_pwr, 0);
    tick();
    chk("R7 ack one cycle", full_ack, 0);
  endtask

  task automatic go_full(int d);
    send_req(1'b0);
    tick();
    finish_full(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset(40);
    bring_up(3, 0, 5, 1'b1);

    full_in_run();
    go_low(4, 1'b0);
    send_req(1'b1);
    repeat (3) begin tick(); chk("R11 stays low", low_pwr, 1); chk("R11 no cfg", clk_cfg_req, 0); end
    go_full(2);

    // go-full latched while low reconfiguration is pending
    go_low(3, 1'b1);
    tick();
    finish_full(1);

    for (int i = 0; i < 40; i++) begin
      case (rnd(2))
        0: full_in_run();
        1: begin go_low(rnd(20), 1'b0); repeat (rnd(3)) tick(); go_full(rnd(20)); end
        default: begin go_low(rnd(20), 1'b1); tick(); finish_full(rnd(20)); end
      endcase
      repeat (rnd(4)) tick();
    end

    for (int i = 0; i < 3; i++) begin
      do_reset(40);
      bring_up(rnd(20), rnd(20), rnd(20), i[0]);
      full_in_run();
    end

    // timeout during first clock configuration
    do_reset(5);
    wait_clk_en();
    repeat (6) begin chk("R10 no fault yet", fault, 0); tick(); end
    chk("R10 fault raised", fault, 1);
    chk("R10 requests off", clk_cfg_req, 0);
    clk_cfg_done = 1; run_ok = 1; mbox_irq = 1; tick();
    clk_cfg_done = 0; run_ok = 0; mbox_irq = 0;
    repeat (3) tick();
    chk("R10 fault sticky", fault, 1);
    chk("R10 no pad req", pad_cfg_req, 0);

    // timeout during low reconfiguration
    do_reset(5);
    bring_up(5, 2, 0, 1'b0);
    send_req(1'b1);
    tick();
    chk("R6 low cfg req", clk_cfg_req, 1);
    repeat (6) begin chk("R10 low wait ok", fault, 0); tick(); end
    chk("R10 low timeout fault", fault, 1);
    chk("R10 low not reached", low_pwr, 0);
    do_reset(5);
    chk("R10 reset clears fault", fault, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule